// File: doc/BRIEF.md
# Register-Driven Camera Control Bus Master

This block lets a host program a camera sensor over a two-wire serial control bus (SCCB) without driving start and stop conditions by hand. The host fills a few byte registers: the slave address, a sub-address and data byte for writes, and a sub-address for reads. It then writes a command code to the command register. A command engine runs the whole bus transaction and reports the outcome through a status byte. That byte has a separate done code for each direction. A completed read leaves the fetched byte in a result register.

Both bus lines are open-drain. The block only ever pulls SCL or SDA low, and releases the line to let the pull-up raise it. SCL comes from the system clock through a parameterised quarter-period divider. There is no clock stretching and no arbitration. A guard register must hold an allowed value before any bus traffic may start.

Top module: `sccb_reg_bridge`

## Requirements
- R1: Register offsets are: 0 command, 1 status, 2 bus guard, 3 slave address, 4 write sub-address, 5 write data, 8 read sub-address, 9 read result. Offsets 2 to 5 and 8 read back what was written. Offset 0 and unmapped offsets read 0x00. After reset the status, guard, sub-address, data and result registers hold 0x00, and the slave address register holds 0x60.
- R2: Writing 0x05 to offset 0 while enabled and idle runs one frame: START, the byte {slave[7:1],0}, the write sub-address, the write data, then STOP. Each byte goes MSB first. The master releases SDA on every ninth bit.
- R3: Writing 0x70 while enabled and idle runs two frames. The first is START, {slave[7:1],0}, the read sub-address, STOP. The second is START, {slave[7:1],1}, one byte read MSB first, the ninth bit left released as a not-acknowledge, STOP. The byte read appears at offset 9.
- R4: An accepted command sets status to 0x00 on the clock edge that takes the command. Status stays 0x00 until the transfer ends, then reads 0x04 after a write or 0x01 after a read.
- R5: If the guard register holds 0x00 or 0x01, a command causes no bus activity and sets status to 0x80. Any other guard value, for example 0x1E, allows transfers.
- R6: A command written while a transfer is in progress is ignored. Status is not changed and no extra frame follows.
- R7: A write to offset 0 with any code other than 0x05 or 0x70 is ignored. Status is unchanged and there is no bus activity.
- R8: Within a byte, each SCL high time lasts 2*QDIV system clocks. SDA changes only while SCL is low, except at START (SDA falls with SCL high) and STOP (SDA rises with SCL high).
- R9: Outputs are pull-low enables. When no transfer is in progress, both lines are released.
- R10: The address byte on the bus is taken from the slave address register, so a new value there selects a different device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Host register write strobe |
| regAddr | input | 4 | Host register offset |
| regWdata | input | 8 | Host write data |
| regRdata | output | 8 | Host read data (combinational on regAddr) |
| sdaIn | input | 1 | Sensed level of the SDA line |
| sclOe | output | 1 | Pull SCL low when 1 |
| sdaOe | output | 1 | Pull SDA low when 1 |

## Verification
The in-RTL properties check several things on every cycle. SDA holds still while SCL is high inside a byte. Both lines are released whenever the engine is idle. Status only ever takes one of its four legal codes. A refused command leaves the engine idle, and a command arriving mid-transfer does not change the direction in progress. Only the bench scenarios can show the rest. A bus-side sensor model decodes each frame and checks it against a queue of expected frames. This shows that frame contents, the restart ordering of a read, and read data returning to the result register are correct. The scenarios also show that SCL high times match the divider, and that illegal codes and disabled guard values leave the bus silent.

// File: rtl/sccb_bridge_pkg.sv
package sccb_bridge_pkg;

  // which host byte the engine wants loaded into the shifter
  typedef enum logic [2:0] {
    SEL_ADDR_W,
    SEL_TX_SUB,
    SEL_TX_DAT,
    SEL_RX_SUB,
    SEL_ADDR_R,
    SEL_NONE
  } byteSel_e;

  typedef struct packed {
    logic       load;
    byteSel_e   sel;
    logic       shift;
    logic       capture;
    logic       statusWe;
    logic [7:0] statusVal;
  } ctrlStrobes_t;

  localparam logic [7:0] CMD_WRITE   = 8'h05;
  localparam logic [7:0] CMD_READ    = 8'h70;
  localparam logic [7:0] STAT_BUSY   = 8'h00;
  localparam logic [7:0] STAT_RD_OK  = 8'h01;
  localparam logic [7:0] STAT_WR_OK  = 8'h04;
  localparam logic [7:0] STAT_FAIL   = 8'h80;

  localparam logic [3:0] OFS_CMD    = 4'h0;
  localparam logic [3:0] OFS_STATUS = 4'h1;
  localparam logic [3:0] OFS_GUARD  = 4'h2;
  localparam logic [3:0] OFS_SLAVE  = 4'h3;
  localparam logic [3:0] OFS_TX_SUB = 4'h4;
  localparam logic [3:0] OFS_TX_DAT = 4'h5;
  localparam logic [3:0] OFS_RX_SUB = 4'h8;
  localparam logic [3:0] OFS_RX_DAT = 4'h9;

endpackage

// File: rtl/sccb_bridge_regs.sv
module sccb_bridge_regs
  import sccb_bridge_pkg::*;
#(
  parameter logic [7:0] DEFAULT_SLAVE = 8'h60
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWr,
  input  logic [3:0]   regAddr,
  input  logic [7:0]   regWdata,
  output logic [7:0]   regRdata,
  input  ctrlStrobes_t str,
  input  logic         sdaIn,
  output logic         txBit,
  output logic         cmdWrite,
  output logic         cmdRead,
  output logic         busEnabled
);

  logic [7:0] guardR, slaveR, txSubR, txDatR, rxSubR, rxDatR, statusR, shiftR;
  logic       cmdHit;

  assign cmdHit     = regWr && (regAddr == OFS_CMD);
  assign cmdWrite   = cmdHit && (regWdata == CMD_WRITE);
  assign cmdRead    = cmdHit && (regWdata == CMD_READ);
  assign busEnabled = |guardR[7:1];
  assign txBit      = shiftR[7];

  // host-programmed registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      guardR <= '0;
      slaveR <= DEFAULT_SLAVE;
      txSubR <= '0;
      txDatR <= '0;
      rxSubR <= '0;
    end else if (regWr) begin
      case (regAddr)
        OFS_GUARD:  guardR <= regWdata;
        OFS_SLAVE:  slaveR <= regWdata;
        OFS_TX_SUB: txSubR <= regWdata;
        OFS_TX_DAT: txDatR <= regWdata;
        OFS_RX_SUB: rxSubR <= regWdata;
        default: ;
      endcase
    end
  end

  // shifter, result and status, driven by engine strobes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftR  <= 8'hFF;
      rxDatR  <= '0;
      statusR <= STAT_BUSY;
    end else begin
      if (str.load) begin
        case (str.sel)
          SEL_ADDR_W: shiftR <= {slaveR[7:1], 1'b0};
          SEL_ADDR_R: shiftR <= {slaveR[7:1], 1'b1};
          SEL_TX_SUB: shiftR <= txSubR;
          SEL_TX_DAT: shiftR <= txDatR;
          SEL_RX_SUB: shiftR <= rxSubR;
          default:    shiftR <= 8'hFF;
        endcase
      end else if (str.shift) begin
        shiftR <= {shiftR[6:0], sdaIn};
      end
      if (str.capture)  rxDatR  <= shiftR;
      if (str.statusWe) statusR <= str.statusVal;
    end
  end

  always_comb begin
    case (regAddr)
      OFS_STATUS: regRdata = statusR;
      OFS_GUARD:  regRdata = guardR;
      OFS_SLAVE:  regRdata = slaveR;
      OFS_TX_SUB: regRdata = txSubR;
      OFS_TX_DAT: regRdata = txDatR;
      OFS_RX_SUB: regRdata = rxSubR;
      OFS_RX_DAT: regRdata = rxDatR;
      default:    regRdata = 8'h00;
    endcase
  end

  // R4: status only ever holds one of its legal codes
  a_r4_status_legal: assert property (@(posedge clk) disable iff (!rstN)
    (statusR == STAT_BUSY) || (statusR == STAT_RD_OK) ||
    (statusR == STAT_WR_OK) || (statusR == STAT_FAIL));

  // R3: the result register only moves on a capture strobe
  a_r3_result_only_on_capture: assert property (@(posedge clk) disable iff (!rstN)
    !$past(str.capture) |-> $stable(rxDatR));

endmodule

// File: rtl/sccb_bridge_ctrl.sv
module sccb_bridge_ctrl
  import sccb_bridge_pkg::*;
#(
  parameter int QDIV = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdWrite,
  input  logic         cmdRead,
  input  logic         busEnabled,
  input  logic         txBit,
  output ctrlStrobes_t str,
  output logic         sclLow,
  output logic         sdaLow
);

  localparam int DIV_W = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(QDIV - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS, S_STOP} state_e;

  state_e           state;
  logic [1:0]       phase;
  logic [DIV_W-1:0] divCnt;
  logic [3:0]       bitIdx;
  logic [1:0]       byteIdx;
  logic             isRead;
  logic             tick, cmdAny, rdByte, lastOfGroup, restartDue;

  assign tick        = (divCnt == DIV_LAST);
  assign cmdAny      = cmdWrite || cmdRead;
  assign rdByte      = isRead && (byteIdx == 2'd3);
  assign lastOfGroup = isRead ? (byteIdx == 2'd1 || byteIdx == 2'd3) : (byteIdx == 2'd2);
  assign restartDue  = isRead && (byteIdx == 2'd1);

  function automatic byteSel_e selFor(logic rd, logic [1:0] idx);
    case (idx)
      2'd0:    return SEL_ADDR_W;
      2'd1:    return rd ? SEL_RX_SUB : SEL_TX_SUB;
      2'd2:    return rd ? SEL_ADDR_R : SEL_TX_DAT;
      default: return SEL_NONE;
    endcase
  endfunction

  always_comb begin
    str     = '0;
    str.sel = SEL_NONE;
    if (state == S_IDLE) begin
      if (cmdAny) begin
        str.statusWe  = 1'b1;
        str.statusVal = busEnabled ? STAT_BUSY : STAT_FAIL;
      end
    end else if (tick && phase == 2'd3) begin
      case (state)
        S_START: begin
          str.load = 1'b1;
          str.sel  = selFor(isRead, byteIdx);
        end
        S_BITS: begin
          if (bitIdx < 4'd8) str.shift = 1'b1;
          else begin
            if (!lastOfGroup) begin
              str.load = 1'b1;
              str.sel  = selFor(isRead, byteIdx + 2'd1);
            end
            if (rdByte) str.capture = 1'b1;
          end
        end
        S_STOP: begin
          if (!restartDue) begin
            str.statusWe  = 1'b1;
            str.statusVal = isRead ? STAT_RD_OK : STAT_WR_OK;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      phase   <= '0;
      divCnt  <= '0;
      bitIdx  <= '0;
      byteIdx <= '0;
      isRead  <= 1'b0;
      sclLow  <= 1'b0;
      sdaLow  <= 1'b0;
    end else if (state == S_IDLE) begin
      if (cmdAny && busEnabled) begin
        state   <= S_START;
        isRead  <= cmdRead;
        byteIdx <= '0;
        phase   <= '0;
        divCnt  <= '0;
      end
    end else begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) begin
        phase <= phase + 2'd1;
        case (state)
          S_START: begin
            if (phase == 2'd1) sdaLow <= 1'b1;
            if (phase == 2'd3) begin
              sclLow <= 1'b1;
              bitIdx <= '0;
              state  <= S_BITS;
            end
          end
          S_BITS: begin
            case (phase)
              2'd0: sclLow <= 1'b1;
              2'd1: sdaLow <= (bitIdx < 4'd8) && !rdByte && !txBit;
              2'd2: sclLow <= 1'b0;
              default: begin
                if (bitIdx == 4'd8) begin
                  bitIdx <= '0;
                  if (lastOfGroup) state <= S_STOP;
                  else byteIdx <= byteIdx + 2'd1;
                end else begin
                  bitIdx <= bitIdx + 4'd1;
                end
              end
            endcase
          end
          S_STOP: begin
            case (phase)
              2'd0: sclLow <= 1'b1;
              2'd1: sdaLow <= 1'b1;
              2'd2: sclLow <= 1'b0;
              default: begin
                sdaLow <= 1'b0;
                if (restartDue) begin
                  byteIdx <= 2'd2;
                  state   <= S_START;
                end else begin
                  state <= S_IDLE;
                end
              end
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  // R8: inside a byte SDA never moves while SCL is released
  a_r8_sda_still_while_scl_high: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BITS && $past(state) == S_BITS && !sclLow && !$past(sclLow))
      |-> $stable(sdaLow));

  // R9: both lines released while idle
  a_r9_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> (!sclLow && !sdaLow));

  // R5: a refused command leaves the engine idle
  a_r5_refused_stays_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && cmdAny && !busEnabled) |=> (state == S_IDLE));

  // R6: a command during a transfer does not change its direction
  a_r6_busy_cmd_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE && cmdAny) |=> $stable(isRead));

endmodule

// File: rtl/sccb_reg_bridge.sv
module sccb_reg_bridge
  import sccb_bridge_pkg::*;
#(
  parameter int         QDIV          = 8,
  parameter logic [7:0] DEFAULT_SLAVE = 8'h60
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWr,
  input  logic [3:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  input  logic       sdaIn,
  output logic       sclOe,
  output logic       sdaOe
);

  ctrlStrobes_t str;
  logic txBit, cmdWrite, cmdRead, busEnabled;

  sccb_bridge_regs #(.DEFAULT_SLAVE(DEFAULT_SLAVE)) uRegs (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .str(str), .sdaIn(sdaIn),
    .txBit(txBit), .cmdWrite(cmdWrite), .cmdRead(cmdRead),
    .busEnabled(busEnabled)
  );

  sccb_bridge_ctrl #(.QDIV(QDIV)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .cmdRead(cmdRead),
    .busEnabled(busEnabled), .txBit(txBit), .str(str),
    .sclLow(sclOe), .sdaLow(sdaOe)
  );

endmodule

// File: tb/sccb_reg_bridge_test.sv
module sccb_reg_bridge_test;

  localparam int QDIV = 8;
  localparam time PERIOD = 8ns;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWr = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       sclOe, sdaOe;
  logic       slvLow = 1'b0;
  logic       sclW, sdaW;

  assign sclW = ~sclOe;
  assign sdaW = ~(sdaOe | slvLow);

  always #(PERIOD/2) clk = ~clk;

  sccb_reg_bridge #(.QDIV(QDIV)) uut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sdaIn(sdaW),
    .sclOe(sclOe), .sdaOe(sdaOe)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---------------- sensor model and scoreboard monitor ----------------
  logic [31:0] expQ[$];
  logic [7:0]  mem [0:255];
  logic [7:0]  fb [0:3];
  logic [7:0]  cur, ptr = 8'h00;
  int          bitPos = 0, nBytes = 0, sclRises = 0;
  bit          inFrame = 0, pulseClean = 0;
  time         riseT = 0, hiMin = 0, hiMax = 0;
  bit          hiSeen = 0;

  always @(negedge sdaW) if (rstN && sclW) begin
    inFrame = 1; bitPos = 0; nBytes = 0; pulseClean = 0;
  end

  always @(posedge sdaW) if (rstN && sclW && inFrame) begin
    logic [31:0] got, exp;
    string req;
    inFrame = 0; pulseClean = 0;
    if (!fb[0][0] && nBytes == 3) begin
      got = {8'd1, fb[0], fb[1], fb[2]}; mem[fb[1]] = fb[2];
    end else if (!fb[0][0] && nBytes == 2) begin
      got = {8'd2, fb[0], fb[1], 8'h00}; ptr = fb[1];
    end else if (fb[0][0] && nBytes == 2) begin
      got = {8'd3, fb[0], fb[1], 8'h00};
    end else begin
      got = {8'd9, fb[0], 8'(nBytes), 8'h00};
    end
    req = (got[31:24] == 8'd1) ? "R2 write frame" : "R3 read frame";
    if (expQ.size() == 0) check({req, " unexpected"}, got, 32'h0);
    else begin
      exp = expQ.pop_front();
      check(req, got, exp);
    end
  end

  always @(posedge sclW) if (rstN) begin
    sclRises++;
    riseT = $time; pulseClean = 1;
    if (inFrame) begin
      if (bitPos < 8) cur = {cur[6:0], sdaW};
      bitPos++;
      if (bitPos == 9) begin
        if (nBytes < 4) fb[nBytes] = cur;
        nBytes++; bitPos = 0;
      end
    end
  end

  always @(negedge sclW) if (rstN) begin
    if (pulseClean && inFrame) begin
      if (!hiSeen || ($time - riseT) < hiMin) hiMin = $time - riseT;
      if (!hiSeen || ($time - riseT) > hiMax) hiMax = $time - riseT;
      hiSeen = 1;
    end
    pulseClean = 0;
    if (inFrame && nBytes == 1 && fb[0][0] && bitPos < 8) slvLow = ~mem[ptr][7-bitPos];
    else slvLow = 1'b0;
  end

  // ---------------- host driver ----------------
  task automatic hostWr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); regWr = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWr = 0;
  endtask

  task automatic hostRd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; #1; d = regRdata;
  endtask

  task automatic waitDone(output logic [7:0] st);
    st = 8'h00;
    for (int i = 0; i < 20000 && st == 8'h00; i++) hostRd(4'h1, st);
  endtask

  task automatic doWrite(logic [7:0] slv, logic [7:0] sub, logic [7:0] dat);
    logic [7:0] st;
    hostWr(4'h4, sub); hostWr(4'h5, dat);
    expQ.push_back({8'd1, slv & 8'hFE, sub, dat});
    hostWr(4'h0, 8'h05);
    repeat (3) @(negedge clk);
    hostRd(4'h1, st); check("R4 pending after write cmd", st, 8'h00);
    waitDone(st); check("R4 write done code", st, 8'h04);
  endtask

  task automatic doRead(logic [7:0] slv, logic [7:0] sub, logic [7:0] val);
    logic [7:0] st, d;
    hostWr(4'h8, sub);
    expQ.push_back({8'd2, slv & 8'hFE, sub, 8'h00});
    expQ.push_back({8'd3, slv | 8'h01, val, 8'h00});
    hostWr(4'h0, 8'h70);
    repeat (3) @(negedge clk);
    hostRd(4'h1, st); check("R4 pending after read cmd", st, 8'h00);
    waitDone(st); check("R4 read done code", st, 8'h01);
    hostRd(4'h9, d); check("R3 result register", d, val);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int edges;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h5A);
    mem[8'h0A] = 8'h96;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset values
    hostRd(4'h1, d); check("R1 status reset", d, 8'h00);
    hostRd(4'h3, d); check("R1 slave reset", d, 8'h60);
    hostRd(4'h2, d); check("R1 guard reset", d, 8'h00);
    hostRd(4'h9, d); check("R1 result reset", d, 8'h00);
    check("R9 idle lines released", {sclOe, sdaOe}, 2'b00);

    // R5 disabled guard values
    edges = sclRises;
    hostWr(4'h0, 8'h05);
    repeat (200) @(negedge clk);
    hostRd(4'h1, d); check("R5 guard 0x00 fails", d, 8'h80);
    check("R5 guard 0x00 no bus activity", sclRises, edges);
    hostWr(4'h2, 8'h01);
    hostWr(4'h0, 8'h70);
    repeat (200) @(negedge clk);
    hostRd(4'h1, d); check("R5 guard 0x01 fails", d, 8'h80);
    check("R5 guard 0x01 no bus activity", sclRises, edges);

    hostWr(4'h2, 8'h1E);
    hostRd(4'h2, d); check("R1 guard readback", d, 8'h1E);
    hostWr(4'h4, 8'h77);
    hostRd(4'h4, d); check("R1 tx sub readback", d, 8'h77);
    hostRd(4'h0, d); check("R1 command reads zero", d, 8'h00);
    hostRd(4'h7, d); check("R1 unmapped reads zero", d, 8'h00);

    // R2 writes with several data patterns
    doWrite(8'h60, 8'h12, 8'hA5);
    doWrite(8'h60, 8'hFF, 8'h00);
    doWrite(8'h60, 8'h00, 8'hFF);
    check("R9 released after transfer", {sclOe, sdaOe}, 2'b00);

    // R3 reads: written value and preset value
    doRead(8'h60, 8'h12, 8'hA5);
    doRead(8'h60, 8'h0A, 8'h96);

    // R6 command during busy is ignored
    hostWr(4'h4, 8'h20); hostWr(4'h5, 8'h5A);
    expQ.push_back({8'd1, 8'h60, 8'h20, 8'h5A});
    hostWr(4'h0, 8'h05);
    repeat (20) @(negedge clk);
    hostWr(4'h0, 8'h70);
    waitDone(d); check("R6 busy command ignored, write code kept", d, 8'h04);
    repeat (3000) @(negedge clk);
    hostRd(4'h1, d); check("R6 no second transfer status", d, 8'h04);
    check("R6 no extra frame queued", expQ.size(), 0);

    // R7 unknown code ignored
    edges = sclRises;
    hostWr(4'h0, 8'h33);
    repeat (300) @(negedge clk);
    hostRd(4'h1, d); check("R7 unknown code keeps status", d, 8'h04);
    check("R7 unknown code no bus activity", sclRises, edges);

    // R10 new slave address
    hostWr(4'h3, 8'h42);
    doWrite(8'h42, 8'h33, 8'hC3);
    doRead(8'h42, 8'h33, 8'hC3);

    // R8 SCL high time inside bytes
    check("R8 min SCL high time", 32'(hiMin / 1ns), 32'(2 * QDIV * 8));
    check("R8 max SCL high time", 32'(hiMax / 1ns), 32'(2 * QDIV * 8));
    check("R2 scoreboard drained", expQ.size(), 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule